// File: doc/BRIEF.md
# Dual Write-Combining Store Queue

This block holds two write-combining queues, each eight 32-bit words wide, in one array of sixteen words. The processor writes and reads single words by address. Address bits 5:2 pick the word, so bit 5 also picks the queue. A flush command sends one complete queue to an external target as a single 32-byte burst write. The whole line is presented on one wide payload bus.

The burst target is formed in one of two ways. In untranslated mode, the block keeps address bits 25:5 of the flush address. It then ORs in a small per-queue high-address register, placed at bit 24. In translated mode, the flush address is already a physical line address and is only masked to 29 bits, with the line offset cleared.

The burst request holds until the receiver accepts it, and a one-cycle done pulse follows acceptance. While a queue is being flushed, writes to that queue are refused with a stall. Writes to the other queue go ahead.

Top module: `wcq_dual`

## Requirements
- R1: After reset, bst_valid and fl_done are low and every word of the array reads as zero.
- R2: A word access uses index acc_addr[5:2]. Address bits 1:0 and 31:6 have no effect on which word is written or read. acc_rdata shows the indexed word combinationally.
- R3: A flush sends the queue chosen by fl_addr[5]: value 0 selects words 0..7 and value 1 selects words 8..15. Word k of the queue sits in bst_data[32k+31:32k], so the lowest word is in the least significant bits.
- R4: With fl_xlate low, bst_addr equals (fl_addr & 32'h03FFFFE0) OR (the selected queue's high register shifted left by 24). The two terms overlap in bits 25:24, where they are ORed.
- R5: A cfg_wr pulse stores cfg_wdata[2:0] into high register cfg_sel, where 0 is queue 0 and 1 is queue 1. Bits 7:3 of cfg_wdata are discarded. Each queue uses only its own register.
- R6: With fl_xlate high, bst_addr equals fl_addr & 32'h1FFFFFE0, and the high registers play no part.
- R7: A flush request taken while idle raises bst_valid on the next cycle. bst_valid, bst_addr and bst_data then hold steady until a cycle with bst_ready high.
- R8: fl_done is high for exactly the one cycle after the cycle in which bst_valid and bst_ready were both high. bst_valid is low in that same cycle.
- R9: During a flush, a write to the queue being sent raises acc_stall in that cycle and leaves the array unchanged. A write to the other queue proceeds with acc_stall low.
- R10: A flush request made while a burst is pending is ignored: bst_addr and bst_data stay those of the pending burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Word write strobe |
| acc_addr | input | 32 | Word access address |
| acc_wdata | input | 32 | Word write data |
| acc_rdata | output | 32 | Word read data |
| acc_stall | output | 1 | Write refused, because its queue is being flushed |
| cfg_wr | input | 1 | High-address register write strobe |
| cfg_sel | input | 1 | High-address register select |
| cfg_wdata | input | 8 | High-address register write data |
| fl_req | input | 1 | Flush command |
| fl_addr | input | 32 | Flush address |
| fl_xlate | input | 1 | Flush address is already translated |
| bst_valid | output | 1 | Burst write request |
| bst_ready | input | 1 | Burst accepted by receiver |
| bst_addr | output | 32 | Burst target address |
| bst_data | output | 256 | Burst payload, word 0 in the low bits |
| fl_done | output | 1 | One-cycle flush completion pulse |

## Verification
The assertions assume that bst_ready comes from a receiver that may stall for any number of cycles. They also assume that the inputs are defined from the first clock after reset. Under those assumptions, the payload, the target and the valid signal are required to hold steady while a burst waits. The stimulus drives every input on the falling edge and never leaves an input undriven. It holds bst_ready low for several cycles before accepting a burst, and it makes its stalled writes and its repeated flush commands only while a burst is pending.

// File: rtl/wcq_dual.sv
module wcq_dual #(
  parameter int DATA_W  = 32,
  parameter int QWORDS  = 8,
  parameter int ADDR_W  = 32,
  parameter int CFG_W   = 8,
  parameter int HI_W    = 3,
  parameter int HI_POS  = 24,
  parameter int UNTR_TOP = 25,
  parameter int XL_TOP  = 28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_wr,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [DATA_W-1:0]        acc_wdata,
  output logic [DATA_W-1:0]        acc_rdata,
  output logic                     acc_stall,
  input  logic                     cfg_wr,
  input  logic                     cfg_sel,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic                     fl_req,
  input  logic [ADDR_W-1:0]        fl_addr,
  input  logic                     fl_xlate,
  output logic                     bst_valid,
  input  logic                     bst_ready,
  output logic [ADDR_W-1:0]        bst_addr,
  output logic [QWORDS*DATA_W-1:0] bst_data,
  output logic                     fl_done
);
  localparam int NWORDS  = 2 * QWORDS;
  localparam int IDX_W   = $clog2(NWORDS);
  localparam int QI_W    = $clog2(QWORDS);
  localparam int OFF     = $clog2(DATA_W / 8);
  localparam int SEL_BIT = OFF + QI_W;
  localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << SEL_BIT;
  localparam logic [ADDR_W-1:0] UNTR_MASK =
      LINE_MASK & ((ADDR_W'(1) << (UNTR_TOP + 1)) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] XL_MASK =
      LINE_MASK & ((ADDR_W'(1) << (XL_TOP + 1)) - ADDR_W'(1));

  logic [DATA_W-1:0] mem [NWORDS];
  logic [HI_W-1:0]   hi_reg [2];
  logic              busy_q;

  wire [IDX_W-1:0] acc_idx = acc_addr[OFF +: IDX_W];
  wire             acc_q   = acc_addr[SEL_BIT];
  wire             fl_q    = fl_addr[SEL_BIT];
  wire [ADDR_W-1:0] hi_ext = {{(ADDR_W-HI_W){1'b0}}, hi_reg[fl_q]} << HI_POS;
  wire [ADDR_W-1:0] tgt    = fl_xlate ? (fl_addr & XL_MASK)
                                      : ((fl_addr & UNTR_MASK) | hi_ext);

  assign acc_stall = acc_wr && bst_valid && (acc_q == busy_q);
  assign acc_rdata = mem[acc_idx];

  for (genvar k = 0; k < QWORDS; k++) begin : g_pay
    assign bst_data[k*DATA_W +: DATA_W] = mem[{busy_q, QI_W'(k)}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (acc_wr && !acc_stall) begin
      mem[acc_idx] <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_reg[0] <= '0;
      hi_reg[1] <= '0;
    end else if (cfg_wr) begin
      hi_reg[cfg_sel] <= cfg_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst_valid <= 1'b0;
      busy_q    <= 1'b0;
      bst_addr  <= '0;
      fl_done   <= 1'b0;
    end else begin
      fl_done <= bst_valid && bst_ready;
      if (!bst_valid && fl_req) begin
        bst_valid <= 1'b1;
        busy_q    <= fl_q;
        bst_addr  <= tgt;
      end else if (bst_valid && bst_ready) begin
        bst_valid <= 1'b0;
      end
    end
  end

  // R7 / R10: a waiting burst keeps its target and payload
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid && !bst_ready |=> bst_valid && $stable(bst_addr) && $stable(bst_data));
  // R8: done follows acceptance by one cycle
  a_r8_done_after: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid && bst_ready |=> fl_done && !bst_valid);
  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fl_done |=> !fl_done);
  // R9: stall only while a burst is pending
  a_r9_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stall |-> bst_valid);
  // R4 / R6: target is always line aligned
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> bst_addr[SEL_BIT-1:0] == '0);
endmodule

// File: tb/wcq_dual_tb.sv
module wcq_dual_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic acc_wr = 0;
  logic [31:0] acc_addr = 0, acc_wdata = 0;
  logic [31:0] acc_rdata;
  logic acc_stall;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic fl_req = 0, fl_xlate = 0, bst_ready = 0;
  logic [31:0] fl_addr = 0;
  logic bst_valid, fl_done;
  logic [31:0] bst_addr;
  logic [255:0] bst_data;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] model [16];

  always #2.5 clk = ~clk;

  wcq_dual u_dut (.clk, .rst_n, .acc_wr, .acc_addr, .acc_wdata, .acc_rdata, .acc_stall,
    .cfg_wr, .cfg_sel, .cfg_wdata, .fl_req, .fl_addr, .fl_xlate, .bst_valid, .bst_ready,
    .bst_addr, .bst_data, .fl_done);

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] line(bit q);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = model[q*8 + k];
    return v;
  endfunction

  task automatic wr_word(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 0;
    model[a[5:2]] = d;
  endtask

  task automatic set_cfg(bit s, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic start_flush(logic [31:0] a, bit x);
    @(negedge clk);
    fl_req = 1; fl_addr = a; fl_xlate = x;
    @(negedge clk);
    fl_req = 0;
  endtask

  task automatic accept(string req);
    bst_ready = 1;
    @(negedge clk);
    bst_ready = 0;
    check({req, " R8 valid drop"}, 256'(bst_valid), 256'(0));
    check({req, " R8 done high"}, 256'(fl_done), 256'(1));
    @(negedge clk);
    check({req, " R8 done pulse"}, 256'(fl_done), 256'(0));
  endtask

  task automatic t_reset;
    check("R1 valid", 256'(bst_valid), 256'(0));
    check("R1 done", 256'(fl_done), 256'(0));
    for (int i = 0; i < 16; i += 5) begin
      acc_addr = 32'(i) << 2;
      #1 check("R1 word", 256'(acc_rdata), 256'(0));
    end
  endtask

  task automatic t_rw;
    for (int i = 0; i < 16; i++)
      wr_word(32'hE000_0000 | (32'(i) << 2) | 32'h3 | (32'(i) << 12), 32'hC0DE_0000 + 32'(i) * 32'h0101);
    for (int i = 0; i < 16; i++) begin
      acc_addr = 32'h1234_5FC0 | (32'(i) << 2) | 32'h1;
      #1 check("R2 readback", 256'(acc_rdata), 256'(model[i]));
    end
  endtask

  task automatic t_untr_q0;
    set_cfg(0, 8'hFD);
    set_cfg(1, 8'h02);
    start_flush(32'hE155_5540, 0);
    check("R7 valid", 256'(bst_valid), 256'(1));
    check("R4 R5 addr q0", 256'(bst_addr), 256'(32'h0555_5540));
    check("R3 data q0", bst_data, line(0));
    // stalled write to q0, free write to q1, ignored second flush
    acc_wr = 1; acc_addr = 32'h0000_0008; acc_wdata = 32'hDEAD_BEEF;
    #1 check("R9 stall q0", 256'(acc_stall), 256'(1));
    @(negedge clk);
    acc_addr = 32'h0000_0024; acc_wdata = 32'h1111_2222;
    #1 check("R9 no stall q1", 256'(acc_stall), 256'(0));
    @(negedge clk);
    acc_wr = 0;
    model[9] = 32'h1111_2222;
    start_flush(32'h0000_0020, 1);
    check("R10 addr kept", 256'(bst_addr), 256'(32'h0555_5540));
    check("R7 R10 data kept", bst_data, line(0));
    check("R7 still valid", 256'(bst_valid), 256'(1));
    check("R8 no early done", 256'(fl_done), 256'(0));
    accept("q0");
    acc_addr = 32'h8;
    #1 check("R9 stalled write dropped", 256'(acc_rdata), 256'(model[2]));
    acc_addr = 32'h24;
    #1 check("R9 other queue written", 256'(acc_rdata), 256'(32'h1111_2222));
  endtask

  task automatic t_untr_q1;
    start_flush(32'h0000_0020, 0);
    check("R4 R5 addr q1", 256'(bst_addr), 256'(32'h0200_0020));
    check("R3 data q1", bst_data, line(1));
    accept("q1");
  endtask

  task automatic t_xlate;
    start_flush(32'hFFFF_FFFF, 1);
    check("R6 addr all ones", 256'(bst_addr), 256'(32'h1FFF_FFE0));
    check("R3 R6 data q1", bst_data, line(1));
    accept("x1");
    start_flush(32'hA123_4547, 1);
    check("R6 addr q0", 256'(bst_addr), 256'(32'h0123_4540));
    check("R3 R6 data q0", bst_data, line(0));
    accept("x0");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_untr_q0();
    t_untr_q1();
    t_xlate();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule